// File: doc/BRIEF.md
# Context-Tagged Translation Cache

This block holds a handful of recent page translations so that most memory accesses can be mapped from a virtual to a physical address without a page-map access. Each entry keeps a context number, a virtual page number, a physical page number and a dirty flag. A lookup compares the request against every entry at once. On a hit it returns the physical address, which is the stored physical page number placed above the unchanged page offset. On a miss it raises a miss flag, and the page-map walker outside the block then supplies the translation through the fill port.

Every entry is tagged with the value of a context register, so translations that belong to different programs can stay in the cache together. A context switch therefore needs no flush. When system software takes a page out of memory, it removes that page's translation with a single-entry invalidate. A full flush is also available. Page-map walking and the choice of which physical page to evict are handled outside this block.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid and the context register is 0, so every lookup misses.
- R2: While `lk_valid` is 1, all entries are compared in the same cycle. Exactly one of `lk_hit` and `lk_miss` is then 1. On a hit, `lk_paddr` is the stored physical page number above the low OFF_W address bits unchanged, and `lk_dirty` is the stored dirty flag. When `lk_valid` is 0, both flags are 0. On a miss, `lk_paddr` and `lk_dirty` are 0.
- R3: The match tag is the context register followed by the virtual page number (address bits above OFF_W). An entry written under a different context never hits. A value loaded through `ctx_load` takes effect from the next cycle.
- R4: A fill writes {context register, `fill_vpn`} → `fill_ppn`, `fill_dirty` into an entry. A lookup in the next cycle hits on it.
- R5: A fill whose tag is already held overwrites that entry in place, so no duplicate is created and no other entry is displaced.
- R6: A fill whose tag is not held goes into the lowest-numbered invalid entry.
- R7: When every entry is valid, a fill with a new tag replaces the entry selected by a rotating pointer. The pointer starts at entry 0 after reset. It moves forward by one, wrapping around, only when it is used.
- R8: An invalidate clears the entry whose tag is {context register, `inv_vpn`}. All other entries are unaffected. An invalidate that matches no entry changes nothing.
- R9: A flush clears every entry in one cycle.
- R10: When requests arrive in the same cycle, flush comes first, then invalidate, then fill. Any request with lower priority in that cycle is dropped.
- R11: With a 10-bit offset: when virtual page 6 is mapped to physical page 2, address 0x1804 hits and gives 0x804. Address 0x1080 misses until virtual page 4 is filled with physical page 5, and after that it gives 0x1480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx_load | input | 1 | Load the context register |
| ctx_in | input | CTX_W | New context number |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent |
| lk_paddr | output | PPN_W+OFF_W | Translated physical address |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Virtual page to fill |
| fill_ppn | input | PPN_W | Physical page for the fill |
| fill_dirty | input | 1 | Dirty flag for the fill |
| inv_valid | input | 1 | Invalidate one translation |
| inv_vpn | input | VPN_W | Virtual page to invalidate |
| flush | input | 1 | Clear all entries |

## Verification
Faults in the stored tags, the valid bits or the replacement pointer show at the ports as a wrong hit or miss, or as a wrong physical page. They appear on the first lookup after the faulty write. After every fill, invalidate, flush and context change, the bench looks up every virtual page under the current context. A wrong victim or a stale entry is therefore exposed within one operation. Pointer errors show up only once the cache is full, so the sequence fills past capacity twice and then checks which translations are gone.

// File: rtl/tlb_pkg.sv
// Shared definitions for the context-tagged translation cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tlb_pkg;
    // Storage operation committed in a cycle, after priority resolution.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_FILL  = 2'd1,
        OP_INV   = 2'd2,
        OP_FLUSH = 2'd3
    } tlb_op_e;
endpackage

// File: rtl/tlb_tag_cmp.sv
// Parallel tag comparator: flags every valid entry whose tag equals the query.
// Assumes tags are packed one per entry and that the valid vector lines up with them.
module tlb_tag_cmp #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 8
) (
    input  logic [ENTRIES-1:0]            valid_vec,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              query,
    output logic [ENTRIES-1:0]            match_vec
);
    // One comparator per entry, all active in the same cycle.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match_vec[i] = valid_vec[i] && (tags[i] == query);
    end
endmodule

// File: rtl/tlb_first_set.sv
// Lowest-index priority encoder: reports whether any bit is set and the lowest such index.
// Assumes IDX_W is wide enough to hold N-1.
module tlb_first_set #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
// Fill slot selection: reuse the matching entry, else the lowest free one, else a rotating pointer.
// Assumes commit is high only in cycles where a fill is written.
module tlb_victim #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               hit_found,
    input  logic [IDX_W-1:0]   hit_idx,
    input  logic               commit,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] rr_q;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
        .vec   (~valid_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    // Choose the slot in the order: same tag, free entry, rotating pointer.
    always_comb begin
        if (hit_found)       victim_idx = hit_idx;
        else if (free_found) victim_idx = free_idx;
        else                 victim_idx = rr_q;
    end

    // Advance the rotating pointer only when it supplied the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (commit && !hit_found && !free_found) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/ctx_tlb.sv
// Fully associative translation cache tagged by {context, virtual page}.
// Lookup is combinational; fill, invalidate, flush and context load take effect at the clock edge.
// Assumes ENTRIES >= 2; priority in one cycle is flush, then invalidate, then fill.
module ctx_tlb #(
    parameter int ENTRIES = 4,
    parameter int CTX_W   = 2,
    parameter int VPN_W   = 6,
    parameter int PPN_W   = 4,
    parameter int OFF_W   = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctx_load,
    input  logic [CTX_W-1:0]       ctx_in,
    input  logic                   lk_valid,
    input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
    output logic                   lk_hit,
    output logic                   lk_miss,
    output logic [PPN_W+OFF_W-1:0] lk_paddr,
    output logic                   lk_dirty,
    input  logic                   fill_valid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic                   fill_dirty,
    input  logic                   inv_valid,
    input  logic [VPN_W-1:0]       inv_vpn,
    input  logic                   flush
);
    import tlb_pkg::*;

    localparam int VA_W  = VPN_W + OFF_W;
    localparam int TAG_W = CTX_W + VPN_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [CTX_W-1:0]                ctx_q;
    logic [ENTRIES-1:0]              valid_q;
    logic [ENTRIES-1:0][TAG_W-1:0]   tag_q;
    logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q;
    logic [ENTRIES-1:0]              dirty_q;

    tlb_op_e          op;
    logic [TAG_W-1:0] lk_tag, req_tag;
    logic [ENTRIES-1:0] lk_match, req_match;
    logic             lk_found, req_found;
    logic [IDX_W-1:0] lk_idx, req_idx, victim_idx;

    // Resolve the single storage operation for this cycle.
    always_comb begin
        if (flush)           op = OP_FLUSH;
        else if (inv_valid)  op = OP_INV;
        else if (fill_valid) op = OP_FILL;
        else                 op = OP_NONE;
    end

    assign lk_tag  = {ctx_q, lk_vaddr[VA_W-1:OFF_W]};
    assign req_tag = {ctx_q, (op == OP_INV) ? inv_vpn : fill_vpn};

    tlb_tag_cmp #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lk_cmp (
        .valid_vec (valid_q), .tags (tag_q), .query (lk_tag), .match_vec (lk_match)
    );
    tlb_tag_cmp #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_req_cmp (
        .valid_vec (valid_q), .tags (tag_q), .query (req_tag), .match_vec (req_match)
    );
    tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
        .vec (lk_match), .found (lk_found), .idx (lk_idx)
    );
    tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_req_enc (
        .vec (req_match), .found (req_found), .idx (req_idx)
    );
    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_q),
        .hit_found  (req_found),
        .hit_idx    (req_idx),
        .commit     (op == OP_FILL),
        .victim_idx (victim_idx)
    );

    // Drive the lookup response from the lowest matching entry.
    always_comb begin
        lk_hit   = lk_valid && lk_found;
        lk_miss  = lk_valid && !lk_found;
        lk_paddr = lk_hit ? {ppn_q[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
        lk_dirty = lk_hit && dirty_q[lk_idx];
    end

    // Hold the current context number.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctx_q <= '0;
        else if (ctx_load) ctx_q <= ctx_in;
    end

    // Maintain entry valid bits under flush, invalidate and fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            case (op)
                OP_FLUSH: valid_q <= '0;
                OP_INV:   valid_q <= valid_q & ~req_match;
                OP_FILL:  valid_q[victim_idx] <= 1'b1;
                default:  valid_q <= valid_q;
            endcase
        end
    end

    // Write the translation payload of a fill into the chosen slot.
    always_ff @(posedge clk) begin
        if (op == OP_FILL) begin
            tag_q[victim_idx]   <= req_tag;
            ppn_q[victim_idx]   <= fill_ppn;
            dirty_q[victim_idx] <= fill_dirty;
        end
    end
endmodule

// File: rtl/ctx_tlb_checker.sv
// Port-level properties of the translation cache, bound onto every instance of ctx_tlb.
// Assumes the bound instance uses the same parameter values.
module ctx_tlb_checker #(
    parameter int CTX_W = 2,
    parameter int VPN_W = 6,
    parameter int PPN_W = 4,
    parameter int OFF_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ctx_load,
    input logic                   lk_valid,
    input logic [VPN_W+OFF_W-1:0] lk_vaddr,
    input logic                   lk_hit,
    input logic                   lk_miss,
    input logic [PPN_W+OFF_W-1:0] lk_paddr,
    input logic                   fill_valid,
    input logic [VPN_W-1:0]       fill_vpn,
    input logic [PPN_W-1:0]       fill_ppn,
    input logic                   inv_valid,
    input logic [VPN_W-1:0]       inv_vpn,
    input logic                   flush
);
    localparam int VA_W = VPN_W + OFF_W;
    localparam int PA_W = PPN_W + OFF_W;

    // R2: a flag only while a lookup is requested, never both.
    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || lk_miss) |-> (lk_valid && !(lk_hit && lk_miss)));

    // R2: every requested lookup is answered in the same cycle.
    p_lookup_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit || lk_miss));

    // R9: nothing hits in the cycle after a flush.
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R8: the invalidated page misses next cycle under the same context.
    p_inv_gone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !ctx_load) |=> (lk_vaddr[VA_W-1:OFF_W] != $past(inv_vpn) || !lk_hit));

    // R4: a committed fill is visible to the next lookup of that page.
    p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_valid && !flush && !ctx_load) |=>
        (!lk_valid || lk_vaddr[VA_W-1:OFF_W] != $past(fill_vpn) ||
         (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_ppn))));
endmodule

bind ctx_tlb ctx_tlb_checker #(
    .CTX_W (CTX_W), .VPN_W (VPN_W), .PPN_W (PPN_W), .OFF_W (OFF_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctx_load   (ctx_load),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_paddr   (lk_paddr),
    .fill_valid (fill_valid),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .inv_valid  (inv_valid),
    .inv_vpn    (inv_vpn),
    .flush      (flush)
);

// File: tb/ctx_tlb_test.sv
// Self-checking bench. After every operation it looks up all virtual pages
// and compares the result with a behavioural model built from the requirements.
module ctx_tlb_test;
    localparam int ENTRIES = 4;
    localparam int CTX_W = 2, VPN_W = 6, PPN_W = 4, OFF_W = 10;
    localparam int NVPN = 1 << VPN_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctx_load = 1'b0; logic [CTX_W-1:0] ctx_in = '0;
    logic lk_valid = 1'b0; logic [VPN_W+OFF_W-1:0] lk_vaddr = '0;
    logic lk_hit, lk_miss, lk_dirty; logic [PPN_W+OFF_W-1:0] lk_paddr;
    logic fill_valid = 1'b0, fill_dirty = 1'b0; logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic inv_valid = 1'b0; logic [VPN_W-1:0] inv_vpn = '0;
    logic flush = 1'b0;

    int checks = 0, errors = 0;

    // Behavioural model state.
    bit m_valid [ENTRIES]; int m_ctx [ENTRIES]; int m_vpn [ENTRIES];
    int m_ppn [ENTRIES]; bit m_dirty [ENTRIES]; int m_rr = 0; int m_cur = 0;

    always #2 clk = ~clk;

    ctx_tlb #(.ENTRIES(ENTRIES), .CTX_W(CTX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) uut (
        .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load), .ctx_in(ctx_in),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_paddr(lk_paddr), .lk_dirty(lk_dirty), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_dirty(fill_dirty), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .flush(flush));

    function automatic int find(int c, int v);
        for (int i = 0; i < ENTRIES; i++)
            if (m_valid[i] && m_ctx[i] == c && m_vpn[i] == v) return i;
        return -1;
    endfunction

    // One clock with the given requests, then update the model per R10.
    task automatic op(bit fl, bit iv, int ivpn, bit fv, int fvpn, int fppn, bit fd, bit cl, int cv);
        @(negedge clk);
        flush = fl; inv_valid = iv; inv_vpn = VPN_W'(ivpn); fill_valid = fv;
        fill_vpn = VPN_W'(fvpn); fill_ppn = PPN_W'(fppn); fill_dirty = fd;
        ctx_load = cl; ctx_in = CTX_W'(cv);
        @(negedge clk);
        flush = 0; inv_valid = 0; fill_valid = 0; ctx_load = 0;
        if (fl) begin
            for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
        end else if (iv) begin
            for (int i = 0; i < ENTRIES; i++)
                if (m_valid[i] && m_ctx[i] == m_cur && m_vpn[i] == ivpn) m_valid[i] = 0;
        end else if (fv) begin
            int s;
            s = find(m_cur, fvpn);
            if (s < 0)
                for (int i = ENTRIES - 1; i >= 0; i--) if (!m_valid[i]) s = i;
            if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % ENTRIES; end
            m_valid[s] = 1; m_ctx[s] = m_cur; m_vpn[s] = fvpn; m_ppn[s] = fppn; m_dirty[s] = fd;
        end
        if (cl) m_cur = cv;
    endtask

    // Look up one page and compare with the model.
    task automatic look(int vpn, int off, string req);
        int e; bit eh, ed; int ep;
        e = find(m_cur, vpn); eh = (e >= 0);
        ep = eh ? ((m_ppn[e] << OFF_W) | off) : 0; ed = eh ? m_dirty[e] : 1'b0;
        lk_valid = 1; lk_vaddr = (VPN_W+OFF_W)'((vpn << OFF_W) | off);
        #1;
        checks++;
        if (lk_hit !== eh || lk_miss !== !eh || lk_paddr !== (PPN_W+OFF_W)'(ep) || lk_dirty !== ed) begin
            errors++;
            $display("FAIL %s vpn=%0d act hit=%b miss=%b pa=%h d=%b exp hit=%b pa=%h d=%b",
                     req, vpn, lk_hit, lk_miss, lk_paddr, lk_dirty, eh, (PPN_W+OFF_W)'(ep), ed);
        end
        lk_valid = 0;
    endtask

    task automatic sweep(string req);
        for (int v = 0; v < NVPN; v++) look(v, (v * 37 + 5) % (1 << OFF_W), req);
    endtask

    // Fixed-value check independent of the model.
    task automatic look_fixed(int va, bit eh, int epa, string req);
        lk_valid = 1; lk_vaddr = (VPN_W+OFF_W)'(va);
        #1;
        checks++;
        if (lk_hit !== eh || (eh && lk_paddr !== (PPN_W+OFF_W)'(epa))) begin
            errors++;
            $display("FAIL %s va=%h act hit=%b pa=%h exp hit=%b pa=%h", req, va, lk_hit, lk_paddr, eh, epa);
        end
        lk_valid = 0;
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        sweep("R1");
        // R11 and R4: document-style translations with a 10-bit offset.
        op(0,0,0, 1,6,2,0, 0,0);
        look_fixed(16'h1804, 1, 14'h0804, "R11");
        sweep("R4");
        look_fixed(16'h1080, 0, 0, "R11");
        op(0,0,0, 1,4,5,1, 0,0);
        look_fixed(16'h1080, 1, 14'h1480, "R11");
        // R3: context isolation.
        op(0,0,0, 0,0,0,0, 1,1);
        sweep("R3");
        op(0,0,0, 1,6,9,0, 0,0);
        sweep("R3");
        op(0,0,0, 0,0,0,0, 1,0);
        look_fixed(16'h1804, 1, 14'h0804, "R3");
        // R5: overwrite in place, R6: lowest free slot.
        op(0,0,0, 1,6,3,1, 0,0);
        sweep("R5");
        op(0,0,0, 1,10,7,0, 0,0);
        sweep("R6");
        // R7: rotating replacement once full.
        op(0,0,0, 1,11,8,1, 0,0);
        sweep("R7");
        op(0,0,0, 1,12,11,0, 0,0);
        sweep("R7");
        // R8: single invalidate, and one that matches nothing.
        op(0,1,10, 0,0,0,0, 0,0);
        sweep("R8");
        op(0,1,33, 0,0,0,0, 0,0);
        sweep("R8");
        op(0,0,0, 1,20,12,1, 0,0);
        sweep("R6");
        op(0,0,0, 1,21,13,0, 0,0);
        sweep("R7");
        op(0,0,0, 0,0,0,0, 1,1);
        sweep("R7");
        op(0,0,0, 0,0,0,0, 1,0);
        // R10: same-cycle priority.
        op(0,0,0, 1,5,1,0, 0,0);
        op(0,1,5, 1,7,2,1, 0,0);
        sweep("R10");
        op(1,0,0, 1,9,4,0, 0,0);
        sweep("R10");
        // R9: flush of a populated cache.
        op(0,0,0, 1,8,6,0, 0,0);
        op(0,0,0, 1,9,7,1, 0,0);
        sweep("R2");
        op(1,0,0, 0,0,0,0, 0,0);
        sweep("R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule